// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Front End

This block is the software-visible control point of one bus-master DMA channel in a disk controller. It holds a command byte, a status byte and a 32-bit descriptor-table base pointer behind a small byte-lane register port. Software starts or stops the channel through the command byte. The block turns those writes into single-cycle strobes for a descriptor engine: begin, cancel, and reload the current descriptor pointer. It also keeps the engine-facing active flag.

The engine reports completion and error through two inputs. The device interrupt line is forwarded unchanged, and a rising edge on it is latched into status. The register port has two words. Word 0 (`reg_sel_i` = 0) carries the command byte in lane 0 and the status byte in lane 2. Lanes 1 and 3 read as zero and ignore writes. Word 1 (`reg_sel_i` = 1) is the base pointer, with byte lane n holding pointer bits 8n+7:8n. A 1-, 2- or 4-byte access is expressed through `reg_be_i`.

Top module: `bmdma_regs`

## Requirements
- R1: A command write (word 0, lane 0 enabled) stores the written byte ANDed with 0x09, so only bit 0 (start) and bit 3 (direction) are kept. `dir_o` follows stored bit 3.
- R2: A command write whose bit 0 equals the stored start bit produces no start, cancel or reload strobe and leaves the active flag unchanged.
- R3: A command write that changes the start bit from 0 to 1 copies the base pointer into `cur_ptr_o` and pulses `reload_o`. If the active flag was clear, it also sets active (status bit 0) and pulses `start_o`. All of these are visible in the cycle after the write edge.
- R4: A command write that changes the start bit from 1 to 0 pulses `cancel_o` and clears the active flag in the cycle after the write edge.
- R5: A status write (word 0, lane 2 enabled) loads status bits 5 and 6 from the written data. Status bit 0 keeps its value. Bits 3, 4 and 7 always read as zero.
- R6: Status bit 1 (error) and bit 2 (interrupt) are cleared by writing 1 and unchanged by writing 0. A set event in the same cycle wins over the clear.
- R7: `irq_o` equals `dev_irq_i` at all times. A 0-to-1 change of `dev_irq_i` sets status bit 2. A steady high level or a falling edge leaves status unchanged.
- R8: Base-pointer writes update only the enabled byte lanes. Pointer bits 1:0 always read as zero.
- R9: While `rst_ni` is low, command, status, base pointer, current pointer, strobes and the edge detector are all zero.
- R10: `eng_done_i` clears the active flag, and `eng_err_i` sets status bit 1. A start in the same cycle takes priority over `eng_done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_sel_i | input | 1 | Word select: 0 command/status, 1 base pointer |
| reg_we_i | input | 1 | Write strobe |
| reg_be_i | input | 4 | Byte-lane enables |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data of the selected word |
| dev_irq_i | input | 1 | Device interrupt level |
| irq_o | output | 1 | Forwarded interrupt level |
| eng_done_i | input | 1 | Engine finished, no more work |
| eng_err_i | input | 1 | Engine reported an error |
| active_o | output | 1 | Channel active flag (status bit 0) |
| dir_o | output | 1 | Transfer direction (command bit 3) |
| start_o | output | 1 | One-cycle begin strobe to engine |
| cancel_o | output | 1 | One-cycle cancel strobe to engine |
| reload_o | output | 1 | One-cycle pointer reload strobe |
| cur_ptr_o | output | 32 | Current descriptor pointer |

## Verification
Directed sequences first cover the four start-bit cases: a 0-to-1 change, a repeat of 1, a repeat of 0 after completion, and a 1-to-0 change. This separates edge-triggered from level-triggered start decoding. Status writes are made with all ones and with all zeros over latched error and interrupt bits, which distinguishes write-one-to-clear from plain load and from ignored writes. Pointer writes with single, half-word and full byte-enable patterns expose lane crosstalk and a missing low-bit clamp. A long run of randomly mixed register writes, interrupt toggles and engine events then stresses same-cycle collisions between set and clear sources against a bench reference.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int LANES = 4;
  localparam int DW    = LANES * 8;

  localparam int CMD_LANE = 0;
  localparam int ST_LANE  = 2;

  localparam int          CMD_GO   = 0;
  localparam int          CMD_DIR  = 3;
  localparam logic [7:0]  CMD_KEEP = 8'h09;

  localparam int          ST_ACT  = 0;
  localparam int          ST_ERR  = 1;
  localparam int          ST_INT  = 2;
  localparam logic [7:0]  ST_FREE = 8'h60;

  localparam logic [7:0]  PTR_LOW_MASK = 8'hFC;
endpackage

// File: rtl/bmdma_cmd_reg.sv
module bmdma_cmd_reg
  import bmdma_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       active_i,
  output logic [7:0] cmd_o,
  output logic       go_rise_o,
  output logic       go_fall_o,
  output logic       start_o,
  output logic       cancel_o,
  output logic       reload_o
);
  logic [7:0] cmd_q;
  logic       start_q, cancel_q, reload_q;

  always_comb begin
    go_rise_o = wr_i &  wdata_i[CMD_GO] & ~cmd_q[CMD_GO];
    go_fall_o = wr_i & ~wdata_i[CMD_GO] &  cmd_q[CMD_GO];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q    <= '0;
      start_q  <= 1'b0;
      cancel_q <= 1'b0;
      reload_q <= 1'b0;
    end else begin
      if (wr_i) cmd_q <= wdata_i & CMD_KEEP;
      start_q  <= go_rise_o & ~active_i;
      cancel_q <= go_fall_o;
      reload_q <= go_rise_o;
    end
  end

  assign cmd_o    = cmd_q;
  assign start_o  = start_q;
  assign cancel_o = cancel_q;
  assign reload_o = reload_q;
endmodule

// File: rtl/bmdma_stat_reg.sv
module bmdma_stat_reg
  import bmdma_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       act_set_i,
  input  logic       act_clr_i,
  input  logic       err_set_i,
  input  logic       irq_i,
  output logic [7:0] stat_o
);
  logic       act_q, err_q, int_q, irq_q;
  logic [7:0] free_q;
  logic       err_w1c, int_w1c, irq_edge;

  always_comb begin
    err_w1c  = wr_i & wdata_i[ST_ERR];
    int_w1c  = wr_i & wdata_i[ST_INT];
    irq_edge = irq_i & ~irq_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      err_q  <= 1'b0;
      int_q  <= 1'b0;
      irq_q  <= 1'b0;
      free_q <= '0;
    end else begin
      irq_q <= irq_i;
      if (act_set_i)      act_q <= 1'b1;
      else if (act_clr_i) act_q <= 1'b0;
      err_q <= (err_q & ~err_w1c) | err_set_i;
      int_q <= (int_q & ~int_w1c) | irq_edge;
      if (wr_i) free_q <= wdata_i & ST_FREE;
    end
  end

  always_comb begin
    stat_o         = free_q;
    stat_o[ST_ACT] = act_q;
    stat_o[ST_ERR] = err_q;
    stat_o[ST_INT] = int_q;
  end
endmodule

// File: rtl/bmdma_ptr_reg.sv
module bmdma_ptr_reg
  import bmdma_pkg::*;
#(
  parameter int NL = LANES,
  localparam int W = NL * 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [NL-1:0] be_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          reload_i,
  output logic [W-1:0]  base_o,
  output logic [W-1:0]  cur_o
);
  logic [W-1:0] base_q, cur_q;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    localparam logic [7:0] KEEP = (l == 0) ? PTR_LOW_MASK : 8'hFF;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              base_q[l*8 +: 8] <= '0;
      else if (wr_i && be_i[l]) base_q[l*8 +: 8] <= wdata_i[l*8 +: 8] & KEEP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cur_q <= '0;
    else if (reload_i) cur_q <= base_q;
  end

  assign base_o = base_q;
  assign cur_o  = cur_q;
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_sel_i,
  input  logic          reg_we_i,
  input  logic [LANES-1:0] reg_be_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          dev_irq_i,
  output logic          irq_o,
  input  logic          eng_done_i,
  input  logic          eng_err_i,
  output logic          active_o,
  output logic          dir_o,
  output logic          start_o,
  output logic          cancel_o,
  output logic          reload_o,
  output logic [DW-1:0] cur_ptr_o
);
  logic          cmd_wr, st_wr, ptr_wr;
  logic [7:0]    cmd_byte, stat_byte;
  logic          go_rise, go_fall;
  logic [DW-1:0] ptr_base;
  logic          reload_int;

  assign cmd_wr = reg_we_i & ~reg_sel_i & reg_be_i[CMD_LANE];
  assign st_wr  = reg_we_i & ~reg_sel_i & reg_be_i[ST_LANE];
  assign ptr_wr = reg_we_i &  reg_sel_i;

  bmdma_cmd_reg i_cmd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (cmd_wr),
    .wdata_i   (wr_data_i[CMD_LANE*8 +: 8]),
    .active_i  (stat_byte[ST_ACT]),
    .cmd_o     (cmd_byte),
    .go_rise_o (go_rise),
    .go_fall_o (go_fall),
    .start_o   (start_o),
    .cancel_o  (cancel_o),
    .reload_o  (reload_int)
  );

  bmdma_stat_reg i_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (st_wr),
    .wdata_i   (wr_data_i[ST_LANE*8 +: 8]),
    .act_set_i (go_rise & ~stat_byte[ST_ACT]),
    .act_clr_i (go_fall | eng_done_i),
    .err_set_i (eng_err_i),
    .irq_i     (dev_irq_i),
    .stat_o    (stat_byte)
  );

  bmdma_ptr_reg #(.NL(LANES)) i_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (ptr_wr),
    .be_i     (reg_be_i),
    .wdata_i  (wr_data_i),
    .reload_i (go_rise),
    .base_o   (ptr_base),
    .cur_o    (cur_ptr_o)
  );

  always_comb begin
    if (reg_sel_i) begin
      rd_data_o = ptr_base;
    end else begin
      rd_data_o = '0;
      rd_data_o[CMD_LANE*8 +: 8] = cmd_byte;
      rd_data_o[ST_LANE*8 +: 8]  = stat_byte;
    end
  end

  assign reload_o = reload_int;
  assign irq_o    = dev_irq_i;
  assign active_o = stat_byte[ST_ACT];
  assign dir_o    = cmd_byte[CMD_DIR];
endmodule

// File: rtl/bmdma_regs_chk.sv
module bmdma_regs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_sel_i,
  input logic [31:0] rd_data_o,
  input logic        dev_irq_i,
  input logic        eng_err_i,
  input logic        active_o,
  input logic        start_o,
  input logic        cancel_o,
  input logic        reload_o,
  input logic [31:0] cur_ptr_o,
  input logic [31:0] ptr_base,
  input logic [7:0]  stat_byte
);
  assert_start_active_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> active_o);
  assert_cancel_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_o |-> !active_o);
  assert_no_both_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_o, cancel_o}));
  assert_active_only_by_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> start_o);
  assert_reload_copies_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_o |-> cur_ptr_o == ptr_base);
  assert_ptr_aligned_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_sel_i |-> rd_data_o[1:0] == 2'b00);
  assert_irq_latch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dev_irq_i) |=> stat_byte[2]);
  assert_err_latch_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_err_i |=> stat_byte[1]);
endmodule

bind bmdma_regs bmdma_regs_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .reg_sel_i (reg_sel_i),
  .rd_data_o (rd_data_o),
  .dev_irq_i (dev_irq_i),
  .eng_err_i (eng_err_i),
  .active_o  (active_o),
  .start_o   (start_o),
  .cancel_o  (cancel_o),
  .reload_o  (reload_o),
  .cur_ptr_o (cur_ptr_o),
  .ptr_base  (ptr_base),
  .stat_byte (stat_byte)
);

// File: tb/test_bmdma_regs.sv
`timescale 1ns/100ps
module test_bmdma_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_sel_i = 1'b0, reg_we_i = 1'b0;
  logic [3:0]  reg_be_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        dev_irq_i = 1'b0, irq_o, eng_done_i = 1'b0, eng_err_i = 1'b0;
  logic        active_o, dir_o, start_o, cancel_o, reload_o;
  logic [31:0] cur_ptr_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [7:0]  m_cmd, m_stat;
  logic [31:0] m_base, m_cur;
  logic        m_irq_q, e_start, e_cancel, e_reload;

  bmdma_regs i_bmdma_regs (.*);

  always #2 clk_i = ~clk_i;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_word();
    return {8'h00, m_stat, 8'h00, m_cmd};
  endfunction

  // reference update for one clock edge
  task automatic model(logic sel, logic we, logic [3:0] be, logic [31:0] wd,
                       logic irq, logic done, logic err);
    logic act, rise, fall;
    act = m_stat[0];
    rise = we && !sel && be[0] && wd[0] && !m_cmd[0];
    fall = we && !sel && be[0] && !wd[0] && m_cmd[0];
    e_start = rise && !act; e_cancel = fall; e_reload = rise;
    if (rise) m_cur = m_base;
    if (rise && !act) act = 1'b1;
    else if (fall || done) act = 1'b0;
    if (we && !sel && be[2]) begin
      if (wd[17]) m_stat[1] = 1'b0;
      if (wd[18]) m_stat[2] = 1'b0;
      m_stat[6:5] = wd[22:21];
    end
    if (err) m_stat[1] = 1'b1;
    if (irq && !m_irq_q) m_stat[2] = 1'b1;
    m_irq_q = irq;
    m_stat[0] = act;
    if (we && !sel && be[0]) m_cmd = wd[7:0] & 8'h09;
    if (we && sel)
      for (int l = 0; l < 4; l++)
        if (be[l]) m_base[l*8 +: 8] = wd[l*8 +: 8];
    m_base[1:0] = 2'b00;
  endtask

  task automatic compare(string req);
    logic keep_sel;
    keep_sel = reg_sel_i;
    reg_sel_i = 1'b0; #0.3;
    chk({req, " R1 R5 R6 ctrl"}, rd_data_o, ctrl_word());
    reg_sel_i = 1'b1; #0.3;
    chk({req, " R8 base"}, rd_data_o, m_base);
    reg_sel_i = keep_sel;
    chk({req, " R3 cur_ptr"}, cur_ptr_o, m_cur);
    chk({req, " R2 strobes"}, {29'd0, start_o, cancel_o, reload_o},
        {29'd0, e_start, e_cancel, e_reload});
    chk({req, " R10 active/dir"}, {30'd0, active_o, dir_o}, {30'd0, m_stat[0], m_cmd[3]});
  endtask

  task automatic step(string req, logic sel, logic we, logic [3:0] be,
                      logic [31:0] wd, logic irq, logic done, logic err);
    @(negedge clk_i);
    reg_sel_i = sel; reg_we_i = we; reg_be_i = be; wr_data_i = wd;
    dev_irq_i = irq; eng_done_i = done; eng_err_i = err;
    #0.2;
    chk("R7 irq pass", {31'd0, irq_o}, {31'd0, irq});
    model(sel, we, be, wd, irq, done, err);
    @(posedge clk_i); #0.2;
    reg_we_i = 1'b0; eng_done_i = 1'b0; eng_err_i = 1'b0;
    compare(req);
  endtask

  initial begin
    void'($urandom(32'd4242));
    m_cmd = '0; m_stat = '0; m_base = '0; m_cur = '0; m_irq_q = 1'b0;
    e_start = 0; e_cancel = 0; e_reload = 0;
    repeat (3) @(posedge clk_i);
    #0.5; compare("R9 reset");
    @(negedge clk_i); rst_ni = 1'b1;
    // pointer lanes
    step("R8 full", 1, 1, 4'hF, 32'hDEADBEEF, 0, 0, 0);
    step("R8 byte2", 1, 1, 4'h4, 32'h0055_0000, 0, 0, 0);
    step("R8 half", 1, 1, 4'h3, 32'h0000_1237, 0, 0, 0);
    // start 0->1 with extra bits
    step("R3 start", 0, 1, 4'h1, 32'h0000_00FF, 0, 0, 0);
    step("R2 repeat1", 0, 1, 4'h1, 32'h0000_0001, 0, 0, 0);
    step("R10 done", 0, 0, 4'h0, 32'h0, 0, 1, 0);
    step("R2 repeat1 idle", 0, 1, 4'h1, 32'h0000_0009, 0, 0, 0);
    step("R5 stat ones", 0, 1, 4'h4, 32'h00FF_0000, 0, 0, 0);
    step("R10 err", 0, 0, 4'h0, 32'h0, 0, 0, 1);
    step("R6 w0 keeps", 0, 1, 4'h4, 32'h0000_0000, 0, 0, 0);
    step("R7 rise", 0, 0, 4'h0, 32'h0, 1, 0, 0);
    step("R6 w1c both", 0, 1, 4'h4, 32'h0006_0000, 1, 0, 0);
    step("R7 level high", 0, 0, 4'h0, 32'h0, 1, 0, 0);
    step("R7 fall", 0, 0, 4'h0, 32'h0, 0, 0, 0);
    step("R4 stop", 0, 1, 4'h1, 32'h0000_0008, 0, 0, 0);
    step("R2 repeat0", 0, 1, 4'h1, 32'h0000_0000, 0, 0, 0);
    step("R3 restart", 0, 1, 4'h1, 32'h0000_0001, 0, 0, 0);
    step("R6 set wins", 0, 1, 4'h4, 32'h0002_0000, 0, 0, 1);
    for (int i = 0; i < 600; i++) begin
      logic [3:0] be;
      logic sel;
      sel = ($urandom % 3) == 0;
      case ($urandom % 4)
        0: be = 4'h1; 1: be = 4'h4; 2: be = 4'h3; default: be = 4'hF;
      endcase
      step("random", sel, ($urandom % 2) == 1, be, $urandom,
           ($urandom % 3) == 0, ($urandom % 5) == 0, ($urandom % 7) == 0);
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule